// File: doc/BRIEF.md
# Configurable GPIO Port Pin Controller

This block manages a small group of bidirectional port pins from a simple register bus. One 8-bit configuration byte sets the pin mode for the whole port: whether the pins are driven, whether the internal pull-ups are requested, whether the drive emulates an open-drain output, and whether a threshold-select flag is raised. The same byte arms a pin-level interrupt whose active polarity is selectable. A second register holds the value the pins drive. A third, read-only register returns the pin levels after they pass through a synchronizer.

The block produces per-pin output-enable and drive-value signals for the pad ring, a pull-up request per pin, and a threshold-select status bit. It also produces a level interrupt request for the CPU. That request stays high while any pin of the port sits at the armed level.

The bus is a single-cycle write strobe with an address and write data, plus a combinational read path. Address 0 is the configuration byte, address 1 is the output data register and address 2 is the input data register. Address 3 reads as zero.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the configuration byte and the output data register are zero. `pin_oe`, `pin_pullup`, `thresh_sel` and `irq` are all low.
- R2: A write to address 0 stores bits 0, 1, 2, 4, 5 and 6. Bits 3 and 7 always read back as 0, whatever value was written.
- R3: While configuration bit 0 (output enable) is 0, `pin_oe` is all zero, whatever the open-drain bit and the data register hold.
- R4: With bit 0 set and bit 2 (open drain) clear, every `pin_oe` bit is 1 and `pin_out` equals bits 3:0 of the output data register.
- R5: With bits 0 and 2 both set, `pin_out` is all zero and `pin_oe[i]` is the inverse of data bit i. A data 1 releases the line and a data 0 drives it low.
- R6: Every `pin_pullup` bit equals configuration bit 1.
- R7: `thresh_sel` equals configuration bit 4 and has no other effect.
- R8: A pin level shows in the input data register (address 2, bits 3:0, upper bits 0) exactly two clock edges after it is applied. It is not visible after one edge.
- R9: `irq` stays low while configuration bit 6 (interrupt enable) is 0, even when pins meet the armed level.
- R10: With bit 6 set, `irq` is high when any synchronized pin is high if bit 5 is 0, and when any synchronized pin is low if bit 5 is 1.
- R11: `irq` is a level. It drops in the same cycle that the last matching synchronized pin stops matching.
- R12: Address 1 reads back the output data in bits 3:0 with upper bits 0. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 4 | Raw pin levels from the pads |
| pin_oe | output | 4 | Per-pin output enable |
| pin_out | output | 4 | Per-pin drive value |
| pin_pullup | output | 4 | Per-pin pull-up request |
| thresh_sel | output | 1 | Input threshold select status |
| irq | output | 1 | Level interrupt request |

## Verification
The interrupt output depends on two things: the configuration byte written over the bus, and the synchronized pin levels. Both are registers, so a configuration write and a pin change that reaches the end of the synchronizer can take effect on the same clock edge. The bench times a pin transition so that it leaves the second synchronizer flop on the very edge that stores a new polarity or enable bit. It then checks `irq` just before and just after that edge. In the case where the pins and the polarity flip together, the armed condition stays false on both sides of the edge, so `irq` must stay low throughout. In the case where enable and the pin level rise together, `irq` must go high on exactly that edge and not one cycle later.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef struct packed {
      logic rsv7;
      logic irq_en;
      logic irq_low;
      logic ttl_sel;
      logic rsv3;
      logic open_drn;
      logic pull_en;
      logic out_en;
   } port_cfg_t;

   localparam logic [7:0] CFG_WR_MASK = 8'b0111_0111;

   typedef enum logic [1:0] {
      A_CFG  = 2'd0,
      A_DOUT = 2'd1,
      A_DIN  = 2'd2,
      A_NONE = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
   parameter int NPINS = 4
) (
   input  logic             out_en,
   input  logic             open_drn,
   input  logic             pull_en,
   input  logic [NPINS-1:0] dout,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_pullup
);
   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         always_comb begin
            if (!out_en) begin
               pin_oe[i]  = 1'b0;
               pin_out[i] = open_drn ? 1'b0 : dout[i];
            end else if (open_drn) begin
               pin_oe[i]  = ~dout[i];
               pin_out[i] = 1'b0;
            end else begin
               pin_oe[i]  = 1'b1;
               pin_out[i] = dout[i];
            end
         end
         assign pin_pullup[i] = pull_en;
      end
   endgenerate
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
   parameter int NPINS = 4
) (
   input  logic             irq_en,
   input  logic             irq_low,
   input  logic [NPINS-1:0] pins,
   output logic             irq
);
   logic [NPINS-1:0] hit;

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_hit
         assign hit[i] = irq_low ? ~pins[i] : pins[i];
      end
   endgenerate

   assign irq = irq_en & (|hit);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
   parameter int NPINS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 2,
   parameter int DW          = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_pullup,
   output logic             thresh_sel,
   output logic             irq
);
   import gpio_pkg::*;

   localparam int PAD = DW - NPINS;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("gpio_port_ctrl: DW must be 8");
      end
      if (NPINS < 1 || NPINS > DW) begin : g_bad_npins
         $error("gpio_port_ctrl: NPINS out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
      end
      if (AW < 2) begin : g_bad_aw
         $error("gpio_port_ctrl: AW must be at least 2");
      end
   endgenerate

   port_cfg_t        cfg_q;
   logic [NPINS-1:0] dout_q;
   logic [NPINS-1:0] pin_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         dout_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == AW'(A_CFG))  cfg_q  <= port_cfg_t'(bus_wdata[7:0] & CFG_WR_MASK);
         if (bus_addr == AW'(A_DOUT)) dout_q <= bus_wdata[NPINS-1:0];
      end
   end

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_drive #(.NPINS(NPINS)) u_drive (
      .out_en     (cfg_q.out_en),
      .open_drn   (cfg_q.open_drn),
      .pull_en    (cfg_q.pull_en),
      .dout       (dout_q),
      .pin_oe     (pin_oe),
      .pin_out    (pin_out),
      .pin_pullup (pin_pullup)
   );

   gpio_irq #(.NPINS(NPINS)) u_irq (
      .irq_en  (cfg_q.irq_en),
      .irq_low (cfg_q.irq_low),
      .pins    (pin_sync),
      .irq     (irq)
   );

   assign thresh_sel = cfg_q.ttl_sel;

   logic [DW-1:0] dout_ext, din_ext;
   generate
      if (PAD > 0) begin : g_pad
         assign dout_ext = {{PAD{1'b0}}, dout_q};
         assign din_ext  = {{PAD{1'b0}}, pin_sync};
      end else begin : g_nopad
         assign dout_ext = dout_q;
         assign din_ext  = pin_sync;
      end
   endgenerate

   always_comb begin
      case (bus_addr)
         AW'(A_CFG):  bus_rdata = cfg_q;
         AW'(A_DOUT): bus_rdata = dout_ext;
         AW'(A_DIN):  bus_rdata = din_ext;
         default:     bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int NPINS = 4,
   parameter int AW    = 2,
   parameter int DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_rdata,
   input logic [7:0]       cfg_b,
   input logic [NPINS-1:0] pin_in,
   input logic [NPINS-1:0] sync_b,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] pin_out,
   input logic             irq
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;

   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == '0) |-> (bus_rdata[3] == 1'b0 && bus_rdata[7] == 1'b0));

   p_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_b[0] |-> (pin_oe == '0));

   p_od_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_b[0] && cfg_b[2]) |-> (pin_out == '0));

   p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (sync_b == $past(pin_in, 2)));

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_b[6] |-> !irq);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .cfg_b     (cfg_q),
   .pin_in    (pin_in),
   .sync_b    (pin_sync),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .irq       (irq)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_oe, pin_out, pin_pullup;
   logic       thresh_sel, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_port_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pullup(pin_pullup),
      .thresh_sel(thresh_sel), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [3:0] v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(2'd0, d); chk("R1 cfg", d, 0);
      rd(2'd1, d); chk("R1 data", d, 0);
      chk("R1 oe", pin_oe, 0);
      chk("R1 pullup", pin_pullup, 0);
      chk("R1 thresh", thresh_sel, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_cfg_readback;
      logic [7:0] d;
      wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 all ones", d, 8'h77);
      wr(2'd0, 8'h88); rd(2'd0, d); chk("R2 reserved only", d, 8'h00);
      wr(2'd0, 8'h35); rd(2'd0, d); chk("R2 pattern", d, 8'h35);
      chk("R7 thresh set", thresh_sel, 1);
      chk("R6 pullup off", pin_pullup, 4'h0);
      wr(2'd0, 8'h02); chk("R6 pullup on", pin_pullup, 4'hF);
      chk("R7 thresh clr", thresh_sel, 0);
   endtask

   task automatic t_drive;
      logic [7:0] d;
      wr(2'd1, 8'hA5); rd(2'd1, d); chk("R12 data readback", d, 8'h05);
      rd(2'd3, d); chk("R12 unmapped", d, 0);
      wr(2'd0, 8'h04); chk("R3 od no oe", pin_oe, 0);
      wr(2'd0, 8'h00); chk("R3 plain input", pin_oe, 0);
      wr(2'd0, 8'h01);
      chk("R4 oe all", pin_oe, 4'hF);
      chk("R4 out", pin_out, 4'h5);
      wr(2'd1, 8'h0C); chk("R4 out new", pin_out, 4'hC);
      wr(2'd0, 8'h05);
      chk("R5 od oe", pin_oe, 4'h3);
      chk("R5 od out", pin_out, 4'h0);
      wr(2'd1, 8'h00); chk("R5 od all low", pin_oe, 4'hF);
      wr(2'd1, 8'h0F); chk("R5 od released", pin_oe, 4'h0);
   endtask

   task automatic t_sync;
      logic [7:0] d;
      @(negedge clk);
      pin_in = 4'h9;
      @(negedge clk);
      rd(2'd2, d); chk("R8 one edge", d, 8'h00);
      @(negedge clk);
      rd(2'd2, d); chk("R8 two edges", d, 8'h09);
      set_pins(4'h6); rd(2'd2, d); chk("R8 second value", d, 8'h06);
   endtask

   task automatic t_irq;
      set_pins(4'h0);
      wr(2'd0, 8'h00);
      set_pins(4'h4); chk("R9 disabled high", irq, 0);
      wr(2'd0, 8'h20); set_pins(4'h0); chk("R9 disabled low", irq, 0);
      wr(2'd0, 8'h40); chk("R10 high none", irq, 0);
      set_pins(4'h4); chk("R10 high one", irq, 1);
      set_pins(4'hC); chk("R11 held", irq, 1);
      set_pins(4'h0); chk("R11 drop", irq, 0);
      wr(2'd0, 8'h60); chk("R10 low all low", irq, 1);
      set_pins(4'hF); chk("R11 low none", irq, 0);
      set_pins(4'hB); chk("R10 low one", irq, 1);
      set_pins(4'hF); chk("R11 low drop", irq, 0);
   endtask

   task automatic t_same_edge;
      wr(2'd0, 8'h40);
      set_pins(4'h0);
      @(negedge clk);
      pin_in = 4'hF;
      @(negedge clk);
      chk("R10 before flip", irq, 0);
      bus_addr = 2'd0; bus_wdata = 8'h60; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R10 pins and polarity same edge", irq, 0);
      @(negedge clk);
      chk("R10 after flip", irq, 0);
      wr(2'd0, 8'h00);
      set_pins(4'h0);
      @(negedge clk);
      pin_in = 4'h2;
      @(negedge clk);
      chk("R9 before enable", irq, 0);
      bus_addr = 2'd0; bus_wdata = 8'h40; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R10 enable and pin same edge", irq, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_readback();
      t_drive();
      t_sync();
      t_irq();
      t_same_edge();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule